// File: doc/BRIEF.md
# Receive-Buffer Flow-Control Requester

This block tracks how full one port's receive buffer is and asks the MAC transmit path to send 802.3x flow-control frames. It keeps its own occupancy counter, driven by push and pop strobes from the buffer. When the count reaches a programmable upper threshold, it asks for a frame that stops the link partner, carrying the maximum quanta. When the count later drops under a programmable lower threshold, it asks for a frame with zero quanta, which lets the partner send again.

The gap between the two thresholds gives hysteresis, so each crossing produces exactly one stop request and one restart request. While the port stays congested, the stop request is repeated at a programmable interval so that the partner's pause timer does not run out. Each request is held on a request/acknowledge pair until the transmit side takes it. A pending request is overwritten when the opposite condition appears before the acknowledge. Frame formatting is done elsewhere.

Top module: `pause_frame_req`

## Requirements
- R1: `occ_o` counts up by one on a cycle with `push_i` high and `pop_i` low, and down by one for the reverse. It is unchanged when both are high or both are low. It saturates: a lone push at 2^CNT_W-1 and a lone pop at 0 are ignored.
- R2: After reset, `occ_o`=0, `req_o`=0 and `quanta_o`=0. All three threshold registers are 0, so automatic generation is disabled.
- R3: When generation is enabled, the block is not paused and `occ_o` >= the high threshold, the block enters the paused state. In the following cycle `req_o` is 1 and `quanta_o`=16'hFFFF.
- R4: While paused, occupancy at or above the high threshold raises no further stop request, apart from the refresh in R6.
- R5: When the block is paused and `occ_o` < the low threshold, it leaves the paused state. In the following cycle `req_o` is 1 and `quanta_o`=16'h0000.
- R6: While paused with a nonzero refresh interval N, the stop request (quanta 16'hFFFF) is raised again N cycles after the previous one. An interval of 0 disables the refresh.
- R7: Once raised, `req_o` stays high until a cycle with `ack_i` high. It falls in the next cycle unless a new request arises in that same cycle.
- R8: A new request that arises while one is pending replaces its quanta, and `req_o` stays high.
- R9: When the low threshold is not below the high threshold, no request is generated and the paused state is cleared.
- R10: `cfg_we_i` high loads `cfg_hi_i`, `cfg_lo_i` and `cfg_refresh_i` into the threshold and interval registers at that clock edge. Those registers are used from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Load threshold and interval registers |
| cfg_hi_i | input | CNT_W | High threshold value |
| cfg_lo_i | input | CNT_W | Low threshold value |
| cfg_refresh_i | input | REF_W | Stop-request refresh interval in cycles, 0 = off |
| push_i | input | 1 | One entry written into the receive buffer |
| pop_i | input | 1 | One entry read from the receive buffer |
| ack_i | input | 1 | Transmit side takes the pending request |
| req_o | output | 1 | Flow-control frame requested |
| quanta_o | output | 16 | Pause quanta for the requested frame |
| occ_o | output | CNT_W | Current buffer occupancy |

## Verification
On every cycle the assertions check four things: single-step counting and saturation of the occupancy, that `req_o` holds until acknowledged, that only the two legal quanta values appear, and that no request is raised while the thresholds disable generation. Several properties need a scenario to show them: that a crossing yields exactly one stop request, the exact refresh period, replacement of a pending request, and the cycle in which each request appears. The bench covers these by comparing every cycle against its own model, under directed sequences and seeded random traffic with random threshold writes.

// File: rtl/pause_pkg.sv
package pause_pkg;
  localparam int QW = 16;
  localparam logic [QW-1:0] QUANTA_STOP  = 16'hFFFF;
  localparam logic [QW-1:0] QUANTA_START = 16'h0000;
endpackage

// File: rtl/rxq_occ_counter.sv
module rxq_occ_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [CNT_W-1:0] occ_o
);
  localparam logic [CNT_W-1:0] OCC_MAX = '1;

  logic [CNT_W-1:0] occ_q;
  logic             inc, dec;

  assign inc = push_i && !pop_i && (occ_q != OCC_MAX);
  assign dec = pop_i && !push_i && (occ_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  occ_q <= '0;
    else if (inc) occ_q <= occ_q + 1'b1;
    else if (dec) occ_q <= occ_q - 1'b1;
  end

  assign occ_o = occ_q;
endmodule

// File: rtl/pause_state.sv
module pause_state #(
  parameter int CNT_W = 12,
  parameter int REF_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] occ_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic [CNT_W-1:0] lo_i,
  input  logic [REF_W-1:0] refresh_i,
  output logic             stop_o,
  output logic             start_o
);
  logic             paused_q;
  logic [REF_W-1:0] tmr_q;
  logic             en, first_stop, refr;

  assign en         = lo_i < hi_i;
  assign first_stop = en && !paused_q && (occ_i >= hi_i);
  assign start_o    = en && paused_q && (occ_i < lo_i);
  // refresh fires refresh_i cycles after the previous stop request
  assign refr       = en && paused_q && !start_o && (refresh_i != '0) &&
                      (tmr_q == refresh_i - 1'b1);
  assign stop_o     = first_stop || refr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      paused_q <= 1'b0;
      tmr_q    <= '0;
    end else if (!en) begin
      paused_q <= 1'b0;
      tmr_q    <= '0;
    end else if (stop_o) begin
      paused_q <= 1'b1;
      tmr_q    <= '0;
    end else if (start_o) begin
      paused_q <= 1'b0;
      tmr_q    <= '0;
    end else if (paused_q) begin
      tmr_q    <= tmr_q + 1'b1;
    end
  end
endmodule

// File: rtl/pause_req_hs.sv
module pause_req_hs
  import pause_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stop_i,
  input  logic          start_i,
  input  logic          ack_i,
  output logic          req_o,
  output logic [QW-1:0] quanta_o
);
  logic          req_q;
  logic [QW-1:0] quanta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q    <= 1'b0;
      quanta_q <= QUANTA_START;
    end else if (stop_i) begin
      req_q    <= 1'b1;
      quanta_q <= QUANTA_STOP;
    end else if (start_i) begin
      req_q    <= 1'b1;
      quanta_q <= QUANTA_START;
    end else if (ack_i) begin
      req_q    <= 1'b0;
    end
  end

  assign req_o    = req_q;
  assign quanta_o = quanta_q;
endmodule

// File: rtl/pause_frame_req.sv
module pause_frame_req
  import pause_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int REF_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CNT_W-1:0] cfg_hi_i,
  input  logic [CNT_W-1:0] cfg_lo_i,
  input  logic [REF_W-1:0] cfg_refresh_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             ack_i,
  output logic             req_o,
  output logic [QW-1:0]    quanta_o,
  output logic [CNT_W-1:0] occ_o
);
  logic [CNT_W-1:0] hi_q, lo_q;
  logic [REF_W-1:0] ref_q;
  logic             stop, start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= '0;
      lo_q  <= '0;
      ref_q <= '0;
    end else if (cfg_we_i) begin
      hi_q  <= cfg_hi_i;
      lo_q  <= cfg_lo_i;
      ref_q <= cfg_refresh_i;
    end
  end

  rxq_occ_counter #(.CNT_W(CNT_W)) u_occ (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .push_i(push_i),
    .pop_i (pop_i),
    .occ_o (occ_o)
  );

  pause_state #(.CNT_W(CNT_W), .REF_W(REF_W)) u_state (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .occ_i    (occ_o),
    .hi_i     (hi_q),
    .lo_i     (lo_q),
    .refresh_i(ref_q),
    .stop_o   (stop),
    .start_o  (start)
  );

  pause_req_hs u_hs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stop_i  (stop),
    .start_i (start),
    .ack_i   (ack_i),
    .req_o   (req_o),
    .quanta_o(quanta_o)
  );
endmodule

// File: rtl/pause_frame_req_chk.sv
module pause_frame_req_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             push_i,
  input logic             pop_i,
  input logic             ack_i,
  input logic             req_o,
  input logic [15:0]      quanta_o,
  input logic [CNT_W-1:0] occ_o,
  input logic [CNT_W-1:0] hi_q,
  input logic [CNT_W-1:0] lo_q
);
  localparam logic [CNT_W-1:0] OCC_MAX = '1;

  AST_OCC_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && occ_o != OCC_MAX) |=> (occ_o - $past(occ_o)) == CNT_W'(1)); // R1
  AST_OCC_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && occ_o != '0) |=> ($past(occ_o) - occ_o) == CNT_W'(1)); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && occ_o == OCC_MAX) |=> occ_o == OCC_MAX); // R1
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> req_o); // R7
  AST_QUANTA_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (quanta_o == 16'hFFFF || quanta_o == 16'h0000)); // R3
  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(lo_q < hi_q) && (!req_o || ack_i)) |=> !req_o); // R9
endmodule

bind pause_frame_req pause_frame_req_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .push_i  (push_i),
  .pop_i   (pop_i),
  .ack_i   (ack_i),
  .req_o   (req_o),
  .quanta_o(quanta_o),
  .occ_o   (occ_o),
  .hi_q    (hi_q),
  .lo_q    (lo_q)
);

// File: tb/tb_pause_frame_req.sv
module tb_pause_frame_req;
  localparam int CW = 6;
  localparam int RW = 8;
  localparam logic [CW-1:0] MAXO = '1;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we = 1'b0;
  logic [CW-1:0] cfg_hi = '0, cfg_lo = '0;
  logic [RW-1:0] cfg_ref = '0;
  logic          push = 1'b0, pop = 1'b0, ack = 1'b0;
  logic          req;
  logic [15:0]   quanta;
  logic [CW-1:0] occ;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  // reference state
  logic [CW-1:0] m_occ, m_hi, m_lo;
  logic [RW-1:0] m_ref, m_tmr;
  logic          m_paused, m_req;
  logic [15:0]   m_q;

  always #2.5 clk = ~clk;

  pause_frame_req #(.CNT_W(CW), .REF_W(RW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_hi_i(cfg_hi),
    .cfg_lo_i(cfg_lo), .cfg_refresh_i(cfg_ref), .push_i(push), .pop_i(pop),
    .ack_i(ack), .req_o(req), .quanta_o(quanta), .occ_o(occ)
  );

  function automatic logic [CW-1:0] f_occ(logic [CW-1:0] o, logic pu, logic po);
    if (pu && !po && o != MAXO) return o + 1'b1;
    if (po && !pu && o != '0)   return o - 1'b1;
    return o;
  endfunction

  function automatic logic f_en(logic [CW-1:0] hi, logic [CW-1:0] lo);
    return lo < hi;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  task automatic model_reset();
    m_occ = '0; m_hi = '0; m_lo = '0; m_ref = '0; m_tmr = '0;
    m_paused = 1'b0; m_req = 1'b0; m_q = 16'h0;
  endtask

  task automatic model_step();
    logic en, first, start, refr;
    en    = f_en(m_hi, m_lo);
    first = en && !m_paused && (m_occ >= m_hi);
    start = en && m_paused && (m_occ < m_lo);
    refr  = en && m_paused && !start && (m_ref != 0) && (m_tmr == m_ref - 1'b1);
    if (first || refr)  begin m_req = 1'b1; m_q = 16'hFFFF; end
    else if (start)     begin m_req = 1'b1; m_q = 16'h0000; end
    else if (ack)       m_req = 1'b0;
    if (!en)                  begin m_paused = 1'b0; m_tmr = '0; end
    else if (first || refr)   begin m_paused = 1'b1; m_tmr = '0; end
    else if (start)           begin m_paused = 1'b0; m_tmr = '0; end
    else if (m_paused)        m_tmr = m_tmr + 1'b1;
    m_occ = f_occ(m_occ, push, pop);
    if (cfg_we) begin m_hi = cfg_hi; m_lo = cfg_lo; m_ref = cfg_ref; end
  endtask

  // one clock: model follows the edge, outputs compared at the falling edge
  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    cyc++;
    chk("R1 occ", 32'(occ), 32'(m_occ));
    chk("R7 req", 32'(req), 32'(m_req));
    if (m_req) chk("R8 quanta", 32'(quanta), 32'(m_q));
  endtask

  task automatic idle();
    push = 0; pop = 0; ack = 0; cfg_we = 0;
  endtask

  task automatic cfg(int hi, int lo, int rf);
    cfg_we = 1; cfg_hi = CW'(hi); cfg_lo = CW'(lo); cfg_ref = RW'(rf);
    tick();
    cfg_we = 0;
  endtask

  task automatic fill_to(int target);
    while (int'(m_occ) < target) begin push = 1; pop = 0; tick(); end
    push = 0;
  endtask

  task automatic drain_to(int target);
    while (int'(m_occ) > target) begin pop = 1; push = 0; tick(); end
    pop = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int n;
    model_reset();
    idle();
    repeat (3) @(negedge clk);
    chk("R2 occ", 32'(occ), 0);
    chk("R2 req", 32'(req), 0);
    chk("R2 quanta", 32'(quanta), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2: thresholds reset to 0, so filling raises nothing
    fill_to(12);
    tick();
    chk("R2 disabled after reset", 32'(req), 0);
    drain_to(0);

    // R10 / R3: program and cross the high threshold
    cfg(10, 4, 0);
    fill_to(10);
    tick();
    chk("R3 stop req", 32'(req), 1);
    chk("R3 stop quanta", 32'(quanta), 32'hFFFF);
    repeat (4) tick();
    chk("R7 held without ack", 32'(req), 1);
    ack = 1; tick(); ack = 0;
    chk("R7 dropped after ack", 32'(req), 0);
    fill_to(20);
    repeat (5) tick();
    chk("R4 no second stop", 32'(req), 0);

    // R5 restart below low threshold
    drain_to(3);
    tick();
    chk("R5 start req", 32'(req), 1);
    chk("R5 start quanta", 32'(quanta), 0);
    ack = 1; tick(); ack = 0;

    // R8 replacement before ack
    fill_to(10);
    tick();
    chk("R8 stop pending", 32'(quanta), 32'hFFFF);
    drain_to(3);
    tick();
    chk("R8 replaced req", 32'(req), 1);
    chk("R8 replaced quanta", 32'(quanta), 0);
    ack = 1; tick(); ack = 0;

    // R6 refresh every 5 cycles while paused
    cfg(10, 4, 5);
    fill_to(10);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      ack = 1; tick();
      if (req) n++;
    end
    ack = 0;
    chk("R6 refresh count", 32'(n), 4);
    drain_to(0);
    ack = 1; tick(); tick(); ack = 0;

    // R9 disabled when low >= high, R1 saturation
    cfg(8, 8, 3);
    fill_to(int'(MAXO));
    push = 1; tick(); tick(); push = 0;
    chk("R1 saturate high", 32'(occ), 32'(MAXO));
    chk("R9 no request", 32'(req), 0);
    drain_to(0);
    pop = 1; tick(); pop = 0;
    chk("R1 saturate low", 32'(occ), 0);
    push = 1; pop = 1; tick(); idle();
    chk("R1 push and pop", 32'(occ), 0);

    // random traffic with occasional reconfiguration
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 6000; i++) begin
      if (i % 700 == 0) begin
        cfg_we = 1;
        cfg_hi = CW'($urandom_range(1, 60));
        cfg_lo = CW'($urandom_range(0, 63));
        cfg_ref = RW'($urandom_range(0, 12));
      end else cfg_we = 0;
      n = $urandom_range(0, 99);
      push = (n < 52);
      pop  = ($urandom_range(0, 99) < 48);
      ack  = ($urandom_range(0, 3) == 0);
      tick();
    end
    idle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule